// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small fully associative cache of address translations. Every slot holds a virtual page number, a physical frame number, a set of permission bits, an address-space tag and a global flag. A purely combinational lookup compares the requested page and the current address-space register against every slot at once. It returns a hit flag, the frame, the permission bits and a flag that reports more than one matching slot.

A context switch loads a new value into the current address-space register. This does not flush anything: translations that belong to other spaces stay cached and simply stop matching. An install port writes one slot, either a slot chosen by the caller or one picked by the replacement logic.

A maintenance port removes translations in a single clock cycle. It can clear the whole cache, every slot of one address space, one exact space/page pair, or an inclusive page range inside one space. The page walk that runs after a miss, and any checking of the permission bits, happen outside this block.

Top module: `asid_tlb`

## Requirements
- R1: The lookup hits only when a slot is valid, its tag equals the current address-space register and its page equals `lk_vpn`. On a hit the outputs give that slot's frame and permission bits. On a miss `lk_pfn` and `lk_perm` are zero.
- R2: A valid slot with its global flag set matches the requested page whatever the current address-space register holds.
- R3: A pulse on `ctx_load` copies `ctx_asid` into the current register, seen on `cur_asid` after the next rising edge. It clears no slot, so translations of the earlier space hit again once that space is loaded back.
- R4: Maintenance code 0 (whole cache) clears every slot.
- R5: Maintenance code 1 (one space) clears every slot whose stored tag equals `inv_asid`. The global flag is ignored and other tags are untouched.
- R6: Maintenance code 2 (pair) clears only slots whose tag equals `inv_asid` and whose page equals `inv_vpn_lo`.
- R7: Maintenance code 3 (range) clears slots whose tag equals `inv_asid` and whose page p satisfies `inv_vpn_lo` <= p <= `inv_vpn_hi`. Pages just outside the range, and other tags, are kept.
- R8: A maintenance request takes effect at the next rising edge. A lookup made in the same cycle still sees the contents from before the request.
- R9: When several slots match, the lowest-index slot supplies frame and permissions and `lk_multi` is 1. With exactly one match `lk_multi` is 0.
- R10: An install with `wr_use_slot`=1 writes slot `wr_slot`, and the translation can be looked up from the next cycle. A slot becomes valid only through an install.
- R11: An install with `wr_use_slot`=0 takes the lowest-index invalid slot. When all slots are valid it takes the slot named by a rotating pointer. The pointer is 0 after reset and moves on by one, wrapping, only after an install that used it.
- R12: When an install and a maintenance request arrive in the same cycle, the installed slot ends up valid.
- R13: After reset all slots are invalid and the current address-space register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_load | input | 1 | Load the current address-space register |
| ctx_asid | input | 8 | New address-space value |
| cur_asid | output | 8 | Current address-space register |
| lk_vpn | input | 20 | Page to translate |
| lk_hit | output | 1 | Lookup hit |
| lk_multi | output | 1 | More than one slot matched |
| lk_pfn | output | 16 | Frame of the winning slot |
| lk_perm | output | 4 | Permission bits of the winning slot |
| wr_en | input | 1 | Install request |
| wr_use_slot | input | 1 | 1: use wr_slot, 0: replacement picks the slot |
| wr_slot | input | 4 | Chosen slot index |
| wr_asid | input | 8 | Tag of the new translation |
| wr_vpn | input | 20 | Page of the new translation |
| wr_pfn | input | 16 | Frame of the new translation |
| wr_perm | input | 4 | Permission bits of the new translation |
| wr_global | input | 1 | Global flag of the new translation |
| inv_en | input | 1 | Maintenance request |
| inv_kind | input | 2 | 0 whole, 1 one space, 2 pair, 3 range |
| inv_asid | input | 8 | Tag operand for codes 1 to 3 |
| inv_vpn_lo | input | 20 | Page for code 2, range start for code 3 |
| inv_vpn_hi | input | 20 | Inclusive range end for code 3 |

## Verification
The range test places pages on both sides of each bound and in another space. A design with an exclusive bound, or one that ignores the tag, would drop or keep the wrong page. The replacement test fills every slot and then opens a single hole. A design that advanced the rotating pointer on a fill of that hole, or that always used the pointer, would evict a live translation. Further cases cover a global entry cleared by a one-space request, a duplicate page in two slots, and a maintenance request seen by a lookup in the same cycle. A wrong design would in turn keep the global entry, return the higher slot's frame, or drop the hit one cycle early.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int ASID_W = 8;
  localparam int VPN_W  = 20;
  localparam int PFN_W  = 16;
  localparam int PERM_W = 4;

  typedef logic [ASID_W-1:0] asid_t;
  typedef logic [VPN_W-1:0]  vpn_t;
  typedef logic [PFN_W-1:0]  pfn_t;
  typedef logic [PERM_W-1:0] perm_t;

  typedef struct packed {
    asid_t asid;
    vpn_t  vpn;
    pfn_t  pfn;
    perm_t perm;
    logic  glob;
  } tlb_entry_t;

  typedef enum logic [1:0] {
    KILL_ALL   = 2'd0,
    KILL_SPACE = 2'd1,
    KILL_PAIR  = 2'd2,
    KILL_RANGE = 2'd3
  } kill_kind_e;

  // Tag comparison used by the lookup path.
  function automatic logic tag_hit(tlb_entry_t e, asid_t cur, vpn_t v);
    return (e.glob || (e.asid == cur)) && (e.vpn == v);
  endfunction

  // Selection rule of the maintenance path; the global flag plays no part.
  function automatic logic kill_hit(tlb_entry_t e, kill_kind_e k,
                                    asid_t a, vpn_t lo, vpn_t hi);
    case (k)
      KILL_ALL:   return 1'b1;
      KILL_SPACE: return e.asid == a;
      KILL_PAIR:  return (e.asid == a) && (e.vpn == lo);
      default:    return (e.asid == a) && (e.vpn >= lo) && (e.vpn <= hi);
    endcase
  endfunction
endpackage

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int N = 16
) (
  input  tlb_entry_t [N-1:0] ents,
  input  logic [N-1:0]       valid,
  input  asid_t              cur,
  input  vpn_t               vpn,
  output logic               hit,
  output logic               multi,
  output pfn_t               pfn,
  output perm_t              perm
);
  logic [N-1:0] match_vec;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_vec[g] = valid[g] && tag_hit(ents[g], cur, vpn);
  end

  always_comb begin
    logic found;
    found = 1'b0;
    pfn   = '0;
    perm  = '0;
    for (int i = 0; i < N; i++) begin
      if (match_vec[i] && !found) begin
        found = 1'b1;
        pfn   = ents[i].pfn;
        perm  = ents[i].perm;
      end
    end
  end

  assign hit   = |match_vec;
  assign multi = (match_vec & (match_vec - 1'b1)) != '0;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid,
  input  logic             take,
  output logic [IDX_W-1:0] victim,
  output logic             all_valid
);
  logic [IDX_W-1:0] rr_q;

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = rr_q;
    for (int i = 0; i < N; i++) begin
      if (!valid[i] && !found) begin
        found  = 1'b1;
        victim = IDX_W'(i);
      end
    end
  end

  assign all_valid = &valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (take && all_valid) begin
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_kill_mask.sv
module tlb_kill_mask
  import tlb_pkg::*;
#(
  parameter int N = 16
) (
  input  tlb_entry_t [N-1:0] ents,
  input  logic               en,
  input  kill_kind_e         kind,
  input  asid_t              asid,
  input  vpn_t               lo,
  input  vpn_t               hi,
  output logic [N-1:0]       kill
);
  for (genvar g = 0; g < N; g++) begin : g_kill
    assign kill[g] = en && kill_hit(ents[g], kind, asid, lo, hi);
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter  int ENTRIES = 16,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctx_load,
  input  logic [ASID_W-1:0] ctx_asid,
  output logic [ASID_W-1:0] cur_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic              lk_multi,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              wr_en,
  input  logic              wr_use_slot,
  input  logic [IDX_W-1:0]  wr_slot,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic              wr_global,
  input  logic              inv_en,
  input  logic [1:0]        inv_kind,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic [VPN_W-1:0]  inv_vpn_lo,
  input  logic [VPN_W-1:0]  inv_vpn_hi
);
  tlb_entry_t [ENTRIES-1:0] ents_q;
  logic [ENTRIES-1:0]       valid_q;
  asid_t                    cur_q;

  // Named internal events for the checker.
  logic [ENTRIES-1:0] kill_vec;
  logic [IDX_W-1:0]   victim_idx;
  logic [IDX_W-1:0]   wr_idx;
  logic               all_valid;
  logic               auto_take;

  tlb_lookup #(.N(ENTRIES)) u_lookup (
    .ents  (ents_q),
    .valid (valid_q),
    .cur   (cur_q),
    .vpn   (lk_vpn),
    .hit   (lk_hit),
    .multi (lk_multi),
    .pfn   (lk_pfn),
    .perm  (lk_perm)
  );

  tlb_kill_mask #(.N(ENTRIES)) u_kill (
    .ents (ents_q),
    .en   (inv_en),
    .kind (kill_kind_e'(inv_kind)),
    .asid (inv_asid),
    .lo   (inv_vpn_lo),
    .hi   (inv_vpn_hi),
    .kill (kill_vec)
  );

  assign auto_take = wr_en && !wr_use_slot;

  tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (valid_q),
    .take      (auto_take),
    .victim    (victim_idx),
    .all_valid (all_valid)
  );

  assign wr_idx = wr_use_slot ? wr_slot : victim_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      ents_q  <= '0;
      cur_q   <= '0;
    end else begin
      if (ctx_load) cur_q <= ctx_asid;
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_en && (wr_idx == IDX_W'(i))) begin
          valid_q[i] <= 1'b1;
          ents_q[i]  <= '{asid: wr_asid, vpn: wr_vpn, pfn: wr_pfn,
                          perm: wr_perm, glob: wr_global};
        end else if (kill_vec[i]) begin
          valid_q[i] <= 1'b0;
        end
      end
    end
  end

  assign cur_asid = cur_q;
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctx_load,
  input logic             wr_en,
  input logic             wr_use_slot,
  input logic             inv_en,
  input logic [1:0]       inv_kind,
  input logic             lk_hit,
  input logic             lk_multi,
  input logic [N-1:0]     valid_q,
  input logic [IDX_W-1:0] wr_idx
);
  p_multi_needs_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> lk_hit);

  p_switch_keeps_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_load && !inv_en && !wr_en) |=> $stable(valid_q));

  p_full_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && inv_kind == 2'd0 && !wr_en) |=> (valid_q == '0));

  p_install_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_idx)]);

  p_no_spont_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((valid_q & ~$past(valid_q)) == '0));

  p_fill_hole_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_use_slot && !(&valid_q)) |-> !valid_q[wr_idx]);
endmodule

bind asid_tlb asid_tlb_chk #(.N(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctx_load    (ctx_load),
  .wr_en       (wr_en),
  .wr_use_slot (wr_use_slot),
  .inv_en      (inv_en),
  .inv_kind    (inv_kind),
  .lk_hit      (lk_hit),
  .lk_multi    (lk_multi),
  .valid_q     (valid_q),
  .wr_idx      (wr_idx)
);

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctx_load = 0;
  logic [7:0]  ctx_asid = 0;
  logic [7:0]  cur_asid;
  logic [19:0] lk_vpn = 0;
  logic        lk_hit, lk_multi;
  logic [15:0] lk_pfn;
  logic [3:0]  lk_perm;
  logic        wr_en = 0, wr_use_slot = 0, wr_global = 0;
  logic [3:0]  wr_slot = 0, wr_perm = 0;
  logic [7:0]  wr_asid = 0;
  logic [19:0] wr_vpn = 0;
  logic [15:0] wr_pfn = 0;
  logic        inv_en = 0;
  logic [1:0]  inv_kind = 0;
  logic [7:0]  inv_asid = 0;
  logic [19:0] inv_vpn_lo = 0, inv_vpn_hi = 0;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  asid_tlb u_dut (.*);

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic install(input bit use_slot, input logic [3:0] slot,
                         input logic [7:0] a, input logic [19:0] v,
                         input logic [15:0] f, input logic [3:0] p, input bit g);
    @(negedge clk);
    wr_en = 1; wr_use_slot = use_slot; wr_slot = slot;
    wr_asid = a; wr_vpn = v; wr_pfn = f; wr_perm = p; wr_global = g;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic kill(input logic [1:0] k, input logic [7:0] a,
                      input logic [19:0] lo, input logic [19:0] hi);
    @(negedge clk);
    inv_en = 1; inv_kind = k; inv_asid = a; inv_vpn_lo = lo; inv_vpn_hi = hi;
    @(negedge clk);
    inv_en = 0;
  endtask

  task automatic switch_to(input logic [7:0] a);
    @(negedge clk);
    ctx_load = 1; ctx_asid = a;
    @(negedge clk);
    ctx_load = 0;
  endtask

  task automatic probe(input logic [19:0] v, input bit exp_hit, input string tag);
    lk_vpn = v;
    #2;
    chk(lk_hit == exp_hit, tag, 64'(lk_hit), 64'(exp_hit));
  endtask

  task automatic t_reset;
    chk(cur_asid == 8'd0, "R13 cur_asid", 64'(cur_asid), 0);
    probe(20'h0, 0, "R13 empty after reset");
  endtask

  task automatic t_basic;
    switch_to(8'd1);
    install(0, 0, 8'd1, 20'h12345, 16'hABCD, 4'h5, 0);
    probe(20'h12345, 1, "R1 hit");
    chk(lk_pfn == 16'hABCD, "R1 pfn", 64'(lk_pfn), 64'hABCD);
    chk(lk_perm == 4'h5, "R1 perm", 64'(lk_perm), 64'h5);
    chk(lk_multi == 0, "R9 single match", 64'(lk_multi), 0);
    probe(20'h12346, 0, "R1 other page miss");
    chk(lk_pfn == 0 && lk_perm == 0, "R1 miss zero", 64'({lk_pfn, lk_perm}), 0);
  endtask

  task automatic t_switch;
    switch_to(8'd2);
    chk(cur_asid == 8'd2, "R3 cur_asid", 64'(cur_asid), 2);
    probe(20'h12345, 0, "R3 other space miss");
    switch_to(8'd1);
    probe(20'h12345, 1, "R3 entry survived switch");
  endtask

  task automatic t_global;
    install(0, 0, 8'd7, 20'h00777, 16'h0777, 4'h1, 1);
    install(0, 0, 8'd7, 20'h00778, 16'h0778, 4'h1, 0);
    switch_to(8'd3);
    probe(20'h00777, 1, "R2 global hits any space");
    probe(20'h00778, 0, "R1 non-global other space miss");
  endtask

  task automatic t_space_kill;
    kill(2'd0, 0, 0, 0);
    install(0, 0, 8'd1, 20'h12345, 16'h1, 4'h1, 0);
    install(0, 0, 8'd2, 20'h00500, 16'h2, 4'h2, 0);
    install(0, 0, 8'd7, 20'h00777, 16'h3, 4'h3, 1);
    kill(2'd1, 8'd1, 0, 0);
    switch_to(8'd1);
    probe(20'h12345, 0, "R5 space 1 cleared");
    switch_to(8'd2);
    probe(20'h00500, 1, "R5 space 2 kept");
    probe(20'h00777, 1, "R5 global still present");
    kill(2'd1, 8'd7, 0, 0);
    probe(20'h00777, 0, "R5 global cleared by its tag");
  endtask

  task automatic t_pair_kill;
    kill(2'd0, 0, 0, 0);
    install(0, 0, 8'd1, 20'h30, 16'h30, 4'h0, 0);
    install(0, 0, 8'd1, 20'h31, 16'h31, 4'h0, 0);
    install(0, 0, 8'd2, 20'h30, 16'h32, 4'h0, 0);
    kill(2'd2, 8'd1, 20'h30, 20'h0);
    switch_to(8'd1);
    probe(20'h30, 0, "R6 pair cleared");
    probe(20'h31, 1, "R6 neighbour page kept");
    switch_to(8'd2);
    probe(20'h30, 1, "R6 same page other space kept");
  endtask

  task automatic t_range_kill;
    kill(2'd0, 0, 0, 0);
    for (int i = 0; i < 6; i++)
      install(0, 0, 8'd4, 20'h40 + 20'(i), 16'(i), 4'h0, 0);
    install(0, 0, 8'd5, 20'h42, 16'h99, 4'h0, 0);
    kill(2'd3, 8'd4, 20'h41, 20'h44);
    switch_to(8'd4);
    probe(20'h40, 1, "R7 below start kept");
    probe(20'h41, 0, "R7 start inclusive");
    probe(20'h42, 0, "R7 inside cleared");
    probe(20'h44, 0, "R7 end inclusive");
    probe(20'h45, 1, "R7 above end kept");
    switch_to(8'd5);
    probe(20'h42, 1, "R7 other space kept");
  endtask

  task automatic t_same_cycle;
    kill(2'd0, 0, 0, 0);
    switch_to(8'd1);
    install(0, 0, 8'd1, 20'h60, 16'h60, 4'h0, 0);
    @(negedge clk);
    inv_en = 1; inv_kind = 2'd0;
    probe(20'h60, 1, "R8 lookup sees old contents");
    @(negedge clk);
    inv_en = 0;
    probe(20'h60, 0, "R4 whole cache cleared");
  endtask

  task automatic t_multi;
    kill(2'd0, 0, 0, 0);
    install(1, 4'd7, 8'd1, 20'h70, 16'h2222, 4'h2, 0);
    install(1, 4'd3, 8'd1, 20'h70, 16'h1111, 4'h1, 0);
    probe(20'h70, 1, "R10 slot write visible");
    chk(lk_pfn == 16'h1111, "R9 lowest slot wins", 64'(lk_pfn), 64'h1111);
    chk(lk_multi == 1, "R9 multi flag", 64'(lk_multi), 1);
  endtask

  task automatic t_write_and_kill;
    kill(2'd0, 0, 0, 0);
    @(negedge clk);
    wr_en = 1; wr_use_slot = 0; wr_asid = 8'd1; wr_vpn = 20'h80;
    wr_pfn = 16'h80; wr_global = 0;
    inv_en = 1; inv_kind = 2'd0;
    @(negedge clk);
    wr_en = 0; inv_en = 0;
    probe(20'h80, 1, "R12 install wins over clear");
  endtask

  task automatic t_replace;
    kill(2'd0, 0, 0, 0);
    for (int i = 0; i < 16; i++)
      install(0, 0, 8'd1, 20'h100 + 20'(i), 16'(i), 4'h0, 0);
    probe(20'h10F, 1, "R11 all sixteen slots filled");
    install(0, 0, 8'd1, 20'h200, 16'h200, 4'h0, 0);
    probe(20'h100, 0, "R11 pointer evicts slot 0");
    probe(20'h200, 1, "R11 new entry present");
    install(0, 0, 8'd1, 20'h201, 16'h201, 4'h0, 0);
    probe(20'h101, 0, "R11 pointer moved to slot 1");
    kill(2'd2, 8'd1, 20'h105, 0);
    install(0, 0, 8'd1, 20'h202, 16'h202, 4'h0, 0);
    probe(20'h102, 1, "R11 hole filled, slot 2 kept");
    probe(20'h202, 1, "R11 hole entry present");
    install(0, 0, 8'd1, 20'h203, 16'h203, 4'h0, 0);
    probe(20'h102, 0, "R11 pointer held during hole fill");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_switch();
    t_global();
    t_space_kill();
    t_pair_kill();
    t_range_kill();
    t_same_cycle();
    t_multi();
    t_write_and_kill();
    t_replace();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule